// File: doc/BRIEF.md
# Sense-Configurable External Interrupt Controller

This block gathers up to 32 external interrupt pins and turns them into one interrupt request for a processor. Each pin first crosses into the controller clock domain through a two-stage synchronizer. A per-line sense field then selects the condition that counts as an event: low level, high level, falling edge, rising edge, or either edge. Every event is latched into a sticky detect flag. Software clears a flag by writing a one to its bit. The processor interrupt is raised while any latched flag is also enabled.

Software reaches the block through a single-cycle 32-bit register port. The port has a byte address, a write strobe, write data and combinational read data. Enables are changed only by bit-wise set and clear writes, so no read-modify-write sequence is needed. The synchronized pin levels can be read back directly. In the level modes the detect flag is set again on every cycle that the active level is present. A clear therefore only holds once the pin has gone inactive.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset all enables are 0, all detect flags are 0, every line's sense field reads 0x2 (level high), and `cpuIrq` is low.
- R2: A read at address 0x000 returns the pin levels after the synchronizer. A pin change made between two clock edges is visible after the second following rising edge, and not after the first.
- R3: A write to address 0x008 sets each enable bit whose data bit is 1 and leaves the others unchanged. A read at 0x004 returns the current enable mask. A read at 0x008 returns 0.
- R4: A write to address 0x004 clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R5: `cpuIrq` is high exactly when some line has both its detect flag and its enable bit set.
- R6: The sense field of line n sits in bits 3:0 of the word at address 0x180 + 4*n and reads back as written. Its encoding is 0x1 = low level, 0x2 = high level, 0x4 = falling edge, 0x8 = rising edge, 0xC = both edges.
- R7: An event that matches a line's sense field sets that line's detect flag. The flag stays set after the input returns to idle. Edges are found by comparing consecutive synchronized samples.
- R8: A write to address 0x100 clears each detect flag whose data bit is 1, and a 0 bit has no effect. A line in a level mode whose active level is still present is set again at once.
- R9: When an event and a clear of the same line fall in the same cycle, the event wins and the flag stays set.
- R10: Reads of addresses that map to no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 10 | Byte address of the register access |
| regWe | input | 1 | Write strobe, one write per cycle |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irqPins | input | LINES | External interrupt inputs, asynchronous |
| cpuIrq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that sense fields hold only the five defined codes. The rising-edge property is only meaningful for lines set to code 0x8. They also assume that at most one register write lands per cycle, which the single-address port enforces. The stimulus writes only legal sense codes and drives the pins and the port away from the active edge. It holds pins stable for several cycles between changes, except in the directed test that lines up an edge event with a clear.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int REG_W = 32;
  localparam int ADDR_W = 10;
  localparam int SENSE_W = 4;
  localparam int IDX_W = 5;

  localparam logic [ADDR_W-1:0] OFS_RAW = 10'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 10'h004;
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 10'h008;
  localparam logic [ADDR_W-1:0] OFS_DETECT = 10'h100;
  localparam logic [2:0] CFG_PAGE = 3'b011;

  localparam logic [SENSE_W-1:0] SENSE_LOW = 4'h1;
  localparam logic [SENSE_W-1:0] SENSE_HIGH = 4'h2;
  localparam logic [SENSE_W-1:0] SENSE_FALL = 4'h4;
  localparam logic [SENSE_W-1:0] SENSE_RISE = 4'h8;
  localparam logic [SENSE_W-1:0] SENSE_BOTH = 4'hC;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_RAW,
    RD_EN,
    RD_DET,
    RD_CFG
  } rdSel_t;

  typedef struct packed {
    logic enSetWe;
    logic enClrWe;
    logic detClrWe;
    logic cfgWe;
    logic [IDX_W-1:0] cfgIdx;
    rdSel_t rdSel;
  } regStrobe_t;

endpackage

// File: rtl/ext_irq_regdec.sv
module ext_irq_regdec
  import ext_irq_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output regStrobe_t        strobe
);

  localparam int IDX_LO = 2;

  logic cfgHit;
  logic [IDX_W-1:0] lineIdx;

  assign lineIdx = regAddr[IDX_LO +: IDX_W];
  assign cfgHit = (regAddr[ADDR_W-1 -: 3] == CFG_PAGE) && (regAddr[1:0] == 2'b00)
                  && (32'(lineIdx) < LINES);

  always_comb begin
    strobe = '0;
    strobe.cfgIdx = lineIdx;
    strobe.rdSel = RD_NONE;
    if (cfgHit) begin
      strobe.rdSel = RD_CFG;
      strobe.cfgWe = regWe;
    end else begin
      unique case (regAddr)
        OFS_RAW:    strobe.rdSel = RD_RAW;
        OFS_EN_CLR: begin
          strobe.rdSel = RD_EN;
          strobe.enClrWe = regWe;
        end
        OFS_EN_SET: strobe.enSetWe = regWe;
        OFS_DETECT: begin
          strobe.rdSel = RD_DET;
          strobe.detClrWe = regWe;
        end
        default:    strobe.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic [LINES-1:0] irqPins,
  output logic             cpuIrq
);

  logic [LINES-1:0] syncA;
  logic [LINES-1:0] syncB;
  logic [LINES-1:0] prevB;
  logic [LINES-1:0] enMask;
  logic [LINES-1:0] detMask;
  logic [LINES-1:0] eventVec;
  logic [SENSE_W-1:0] cfgReg [LINES];

  // two-flop synchronizer plus one delayed copy for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= irqPins;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic riseEdge;
    logic fallEdge;
    assign riseEdge = syncB[g] & ~prevB[g];
    assign fallEdge = ~syncB[g] & prevB[g];
    assign eventVec[g] = (cfgReg[g][0] & ~syncB[g]) | (cfgReg[g][1] & syncB[g])
                       | (cfgReg[g][2] & fallEdge) | (cfgReg[g][3] & riseEdge);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgReg[g] <= SENSE_HIGH;
      end else if (strobe.cfgWe && strobe.cfgIdx == IDX_W'(g)) begin
        cfgReg[g] <= regWdata[SENSE_W-1:0];
      end
    end

    // R7: a rising-only line may only latch on a rising sample pair
    a_r7_rise_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(detMask[g]) && $past(cfgReg[g]) == SENSE_RISE) |->
        ($past(syncB[g]) && !$past(prevB[g])));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMask <= '0;
      detMask <= '0;
    end else begin
      if (strobe.enSetWe) enMask <= enMask | regWdata[LINES-1:0];
      else if (strobe.enClrWe) enMask <= enMask & ~regWdata[LINES-1:0];
      // an event in the same cycle as a clear keeps the flag set
      detMask <= (strobe.detClrWe ? (detMask & ~regWdata[LINES-1:0]) : detMask) | eventVec;
    end
  end

  assign cpuIrq = |(detMask & enMask);

  always_comb begin
    unique case (strobe.rdSel)
      RD_RAW:  regRdata = REG_W'(syncB);
      RD_EN:   regRdata = REG_W'(enMask);
      RD_DET:  regRdata = REG_W'(detMask);
      RD_CFG:  regRdata = REG_W'(cfgReg[strobe.cfgIdx]);
      default: regRdata = '0;
    endcase
  end

  // R3: set write forces every selected enable on
  a_r3_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enSetWe |=> ((enMask & $past(regWdata[LINES-1:0])) == $past(regWdata[LINES-1:0])));

  // R4: clear write forces every selected enable off
  a_r4_enable_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enClrWe |=> ((enMask & $past(regWdata[LINES-1:0])) == '0));

  // R5: nothing enabled means no request
  a_r5_quiet_when_masked: assert property (@(posedge clk) disable iff (!rstN)
    (enMask == '0) |-> !cpuIrq);

  // R6: a sense write lands in the addressed line
  a_r6_cfg_store: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cfgWe |=> (cfgReg[$past(strobe.cfgIdx)] == $past(regWdata[SENSE_W-1:0])));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [9:0]       regAddr,
  input  logic             regWe,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [LINES-1:0] irqPins,
  output logic             cpuIrq
);

  regStrobe_t strobe;

  ext_irq_regdec #(.LINES(LINES)) u_regdec (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strobe  (strobe)
  );

  ext_irq_datapath #(.LINES(LINES)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .irqPins  (irqPins),
    .cpuIrq   (cpuIrq)
  );

endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [N-1:0] irqPins = '0;
  logic cpuIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [3:0] mCfg [N];
  logic [31:0] mDet;
  logic [31:0] mEn;
  logic [31:0] mPins;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ext_irq_ctrl #(.LINES(N)) u_ext_irq_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .irqPins(irqPins), .cpuIrq(cpuIrq)
  );

  function automatic logic [31:0] levelHits(input logic [31:0] lvl);
    logic [31:0] r = '0;
    for (int i = 0; i < N; i++) begin
      if (mCfg[i] == 4'h1) r[i] = ~lvl[i];
      if (mCfg[i] == 4'h2) r[i] = lvl[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] eventHits(input logic [31:0] oldL, input logic [31:0] newL);
    logic [31:0] r = levelHits(newL);
    for (int i = 0; i < N; i++) begin
      if (mCfg[i] == 4'h4) r[i] = oldL[i] & ~newL[i];
      if (mCfg[i] == 4'h8) r[i] = ~oldL[i] & newL[i];
      if (mCfg[i] == 4'hC) r[i] = oldL[i] ^ newL[i];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    regAddr = a;
    regWdata = d;
    regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    regWdata = '0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    regWe = 1'b0;
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] m;
    void'($urandom(32'd1357));
    for (int i = 0; i < N; i++) mCfg[i] = 4'h2;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(10'h004, d); chk("R1 enables", d, 32'h0);
    rd(10'h100, d); chk("R1 detect", d, 32'h0);
    rd(10'h180, d); chk("R1 cfg line0", d, 32'h2);
    rd(10'h1FC, d); chk("R1 cfg line31", d, 32'h2);
    chk("R1 cpuIrq", 32'(cpuIrq), 32'h0);

    // R2 synchronizer latency
    irqPins = 32'hA5A5_0F0F;
    @(negedge clk);
    rd(10'h000, d); chk("R2 raw after one edge", d, 32'h0);
    @(negedge clk);
    rd(10'h000, d); chk("R2 raw after two edges", d, 32'hA5A5_0F0F);
    irqPins = '0;
    idle(5);
    mPins = '0;

    // R6 program random legal sense codes, line 3 rising
    for (int i = 0; i < N; i++) begin
      case ($urandom_range(0, 4))
        0: mCfg[i] = 4'h1;
        1: mCfg[i] = 4'h2;
        2: mCfg[i] = 4'h4;
        3: mCfg[i] = 4'h8;
        default: mCfg[i] = 4'hC;
      endcase
      if (i == 3) mCfg[i] = 4'h8;
      wr(10'h180 + 10'(4 * i), {28'h0, mCfg[i]});
    end
    for (int i = 0; i < N; i += 5) begin
      rd(10'h180 + 10'(4 * i), d); chk("R6 cfg readback", d, {28'h0, mCfg[i]});
    end
    idle(5);
    wr(10'h100, 32'hFFFF_FFFF);
    mDet = levelHits(mPins);
    rd(10'h100, d); chk("R8 clear all keeps active levels", d, mDet);

    // R9 edge event coincides with a clear of the same line
    irqPins[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(10'h100, 32'h8);
    rd(10'h100, d); chk("R9 event beats clear", d & 32'h8, 32'h8);
    wr(10'h100, 32'h8);
    rd(10'h100, d); chk("R8 edge line cleared", d & 32'h8, 32'h0);
    irqPins[3] = 1'b0;
    mPins = irqPins;
    idle(5);
    wr(10'h100, 32'hFFFF_FFFF);
    mDet = levelHits(mPins);

    // R10 unmapped addresses; R3 set register reads zero
    rd(10'h00C, d); chk("R10 unmapped 0x00C", d, 32'h0);
    rd(10'h104, d); chk("R10 unmapped 0x104", d, 32'h0);
    rd(10'h182, d); chk("R10 misaligned cfg", d, 32'h0);
    wr(10'h008, 32'h0000_00F0);
    rd(10'h008, d); chk("R3 set register reads zero", d, 32'h0);
    wr(10'h008, 32'h0);
    rd(10'h004, d); chk("R3 zero write no effect", d, 32'h0000_00F0);
    mEn = 32'h0000_00F0;

    // random main loop: R5 R7 R8 R3 R4
    for (int it = 0; it < 60; it++) begin
      logic [31:0] newPins = $urandom();
      irqPins = newPins;
      idle(5);
      mDet = mDet | eventHits(mPins, newPins);
      mPins = newPins;
      rd(10'h100, d); chk("R7 detect latch", d, mDet);
      rd(10'h000, d); chk("R2 raw levels", d, mPins);

      m = $urandom();
      wr(10'h008, m); mEn = mEn | m;
      rd(10'h004, d); chk("R3 enable set", d, mEn);
      m = $urandom() & $urandom();
      wr(10'h004, m); mEn = mEn & ~m;
      rd(10'h004, d); chk("R4 enable clear", d, mEn);
      chk("R5 cpuIrq", 32'(cpuIrq), 32'(|(mDet & mEn)));

      m = (it % 7 == 0) ? 32'h0 : $urandom();
      wr(10'h100, m);
      mDet = (mDet & ~m) | levelHits(mPins);
      rd(10'h100, d); chk("R8 detect clear", d, mDet);
      chk("R5 cpuIrq after clear", 32'(cpuIrq), 32'(|(mDet & mEn)));
    end

    wr(10'h004, 32'hFFFF_FFFF);
    chk("R5 all masked", 32'(cpuIrq), 32'h0);
    finish_run();
  end

endmodule